// File: doc/BRIEF.md
# Debug Trigger Control Register Bank

This block keeps the configuration of a small set of hardware debug triggers (two by default) and serves it through a machine-mode control-register port. Software picks one trigger with a selector register. It then reads or writes that trigger's control word, its address/data comparison word and a third word that is always zero. A read-only capability register lists the supported trigger kinds.

Every write is cleaned up before it is stored. The kind field of a control word must name one of the two supported address/data match kinds: kind 2 (classic) or kind 6 (extended). A write that names any other kind is dropped. The debug-mode bit and every unsupported control field are stored as zero. A size code that does not describe 0, 1, 2, 4 or 8 bytes is replaced by 0, which means any size.

The stored control and comparison words of all triggers are driven out in parallel to a separate match unit. A one-cycle per-trigger strobe tells that unit when a trigger was reconfigured. The register port has no handshake. An access completes in the cycle it is presented and the port never applies back-pressure. Reads are combinational. Writes take effect at the next clock edge.

Top module: `dbg_trig_csr`

## Requirements
- R1: After reset the selector is 0. Every control word reads 0x2000_0000 (kind 2, all other fields zero). Every comparison word and every third word reads 0. No strobe is active.
- R2: A selector write (address 0x7A0) is stored only when the written value is less than NUM_TRIG. Otherwise the previous selection is kept.
- R3: For a control-word write (address 0x7A1), the kind is taken from written bits 31:28. Kinds 2 and 6 are accepted. Any other kind leaves the trigger's words unchanged and raises no strobe.
- R4: The stored control word always has bit 27 (debug mode) equal to 0. The match, chain, action, timing, select and hit fields are also stored as zero.
- R5: A kind-2 write keeps the machine, supervisor and user enables (bits 6, 4, 3) and the execute, store and load enables (bits 2, 1, 0). It also keeps the 2-bit size at bits 17:16.
- R6: A kind-6 write also keeps the virtual-supervisor and virtual-user enables (bits 24, 23). Its 4-bit size at bits 19:16 is kept only for codes 0, 1, 2, 3 and 5. Any other code stores 0.
- R7: A comparison-word write (address 0x7A2) stores the full value into the selected trigger.
- R8: Writes to the third word (address 0x7A3) are ignored, and the third word always reads 0.
- R9: The capability register (address 0x7A4) reads 0x0000_0044, with bits 2 and 6 set.
- R10: An access to any other address reads 0 and changes no state.
- R11: An accepted control-word or comparison-word write updates the trigger's output word at the next edge. The same edge raises that trigger's strobe bit for exactly one cycle. At most one strobe bit is high at a time.
- R12: Reads return the words of the selected trigger only. The output buses carry every trigger's words, trigger i in bits [i*32 +: 32].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 12 | Register address |
| csr_we | input | 1 | Write enable, one write per cycle |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Combinational read data for csr_addr |
| trig_ctrl_o | output | NUM_TRIG*XLEN | Stored control words, all triggers |
| trig_addr_o | output | NUM_TRIG*XLEN | Stored comparison words, all triggers |
| trig_reconf_o | output | NUM_TRIG | One-cycle reconfiguration strobe per trigger |

## Verification
Two functions can overlap in one cycle: the reconfiguration strobe of one trigger and a selector write that moves software to another trigger. The bench writes trigger 0's comparison word and issues a selector write in the very next cycle. It then checks that the strobe still flags trigger 0 while the selection moves, and that later reads come from trigger 1. A second overlap is a read of a control word in the same cycle that it is being rewritten. The bench checks that the read returns the old value before the edge and the cleaned-up value after it.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
  typedef enum logic [3:0] {
    TK_ADDR     = 4'd2,
    TK_ADDR_EXT = 4'd6
  } trig_kind_e;

  localparam logic [11:0] A_SELECT = 12'h7A0;
  localparam logic [11:0] A_CTRL   = 12'h7A1;
  localparam logic [11:0] A_CMP    = 12'h7A2;
  localparam logic [11:0] A_SPARE  = 12'h7A3;
  localparam logic [11:0] A_CAPS   = 12'h7A4;

  // capability mask: one bit per supported kind
  localparam int unsigned CAPS_MASK = (1 << 2) | (1 << 6);

  // legal size codes: any, 1, 2, 4, 8 bytes
  function automatic logic size_legal(input logic [3:0] code);
    return (code <= 4'd3) || (code == 4'd5);
  endfunction

  function automatic logic kind_ok(input logic [3:0] k);
    return (k == TK_ADDR) || (k == TK_ADDR_EXT);
  endfunction
endpackage

// File: rtl/dbg_trig_legal.sv
module dbg_trig_legal import dbg_trig_pkg::*; #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] wdata_i,
  output logic            accept_o,
  output logic [XLEN-1:0] ctrl_o
);
  localparam int KIND_LSB = XLEN - 4;

  logic [3:0] kind;
  logic [3:0] size_classic;
  logic [3:0] size_ext;

  assign kind     = wdata_i[XLEN-1:KIND_LSB];
  assign size_ext = wdata_i[19:16];
  assign accept_o = kind_ok(kind);

  generate
    if (XLEN == 64) begin : g_wide
      assign size_classic = {wdata_i[22:21], wdata_i[17:16]};
    end else begin : g_narrow
      assign size_classic = {2'b00, wdata_i[17:16]};
    end
  endgenerate

  always_comb begin
    ctrl_o                   = '0;
    ctrl_o[XLEN-1:KIND_LSB]  = kind;
    ctrl_o[6]                = wdata_i[6];
    ctrl_o[4:0]              = wdata_i[4:0];
    if (kind == TK_ADDR) begin
      if (size_legal(size_classic)) begin
        ctrl_o[17:16] = wdata_i[17:16];
        if (XLEN == 64) ctrl_o[22:21] = wdata_i[22:21];
      end
    end else if (kind == TK_ADDR_EXT) begin
      ctrl_o[24:23] = wdata_i[24:23];
      if (size_legal(size_ext)) ctrl_o[19:16] = size_ext;
    end
  end
endmodule

// File: rtl/dbg_trig_sel.sv
module dbg_trig_sel #(
  parameter int XLEN     = 32,
  parameter int NUM_TRIG = 2,
  localparam int SEL_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [XLEN-1:0]  wdata_i,
  output logic [SEL_W-1:0] sel_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sel_o <= '0;
    else if (wr_i && (wdata_i < XLEN'(NUM_TRIG)))
      sel_o <= wdata_i[SEL_W-1:0];
  end

  // R2
  sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sel_o) < NUM_TRIG);

  // R2
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !(wdata_i < XLEN'(NUM_TRIG))) |=> $stable(sel_o));
endmodule

// File: rtl/dbg_trig_slot.sv
module dbg_trig_slot import dbg_trig_pkg::*; #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_ctrl_i,
  input  logic            wr_cmp_i,
  input  logic [XLEN-1:0] ctrl_d_i,
  input  logic [XLEN-1:0] cmp_d_i,
  output logic [XLEN-1:0] ctrl_o,
  output logic [XLEN-1:0] cmp_o,
  output logic            reconf_o
);
  localparam int KIND_LSB = XLEN - 4;
  localparam logic [XLEN-1:0] CTRL_RST = XLEN'(TK_ADDR) << KIND_LSB;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o   <= CTRL_RST;
      cmp_o    <= '0;
      reconf_o <= 1'b0;
    end else begin
      if (wr_ctrl_i) ctrl_o <= ctrl_d_i;
      if (wr_cmp_i)  cmp_o  <= cmp_d_i;
      reconf_o <= wr_ctrl_i | wr_cmp_i;
    end
  end

  // R4
  dmode_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_o[XLEN-5] == 1'b0);

  // R3
  kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kind_ok(ctrl_o[XLEN-1:KIND_LSB]));

  // R11
  ctrl_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl_i |=> $stable(ctrl_o));

  // R11
  reconf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl_i || wr_cmp_i) |=> reconf_o);
endmodule

// File: rtl/dbg_trig_csr.sv
module dbg_trig_csr import dbg_trig_pkg::*; #(
  parameter int XLEN     = 32,
  parameter int NUM_TRIG = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [11:0]              csr_addr,
  input  logic                     csr_we,
  input  logic [XLEN-1:0]          csr_wdata,
  output logic [XLEN-1:0]          csr_rdata,
  output logic [NUM_TRIG*XLEN-1:0] trig_ctrl_o,
  output logic [NUM_TRIG*XLEN-1:0] trig_addr_o,
  output logic [NUM_TRIG-1:0]      trig_reconf_o
);
  localparam int SEL_W    = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;
  localparam int KIND_LSB = XLEN - 4;

  logic [SEL_W-1:0] sel;
  logic             legal_ok;
  logic [XLEN-1:0]  legal_ctrl;
  logic [XLEN-1:0]  ctrl_arr [NUM_TRIG];
  logic [XLEN-1:0]  cmp_arr  [NUM_TRIG];

  dbg_trig_sel #(.XLEN(XLEN), .NUM_TRIG(NUM_TRIG)) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (csr_we && (csr_addr == A_SELECT)),
    .wdata_i (csr_wdata),
    .sel_o   (sel)
  );

  dbg_trig_legal #(.XLEN(XLEN)) u_legal (
    .wdata_i  (csr_wdata),
    .accept_o (legal_ok),
    .ctrl_o   (legal_ctrl)
  );

  generate
    for (genvar i = 0; i < NUM_TRIG; i++) begin : g_slot
      logic picked;
      assign picked = csr_we && (int'(sel) == i);

      dbg_trig_slot #(.XLEN(XLEN)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl_i (picked && (csr_addr == A_CTRL) && legal_ok),
        .wr_cmp_i  (picked && (csr_addr == A_CMP) &&
                    kind_ok(ctrl_arr[i][XLEN-1:KIND_LSB])),
        .ctrl_d_i  (legal_ctrl),
        .cmp_d_i   (csr_wdata),
        .ctrl_o    (ctrl_arr[i]),
        .cmp_o     (cmp_arr[i]),
        .reconf_o  (trig_reconf_o[i])
      );

      assign trig_ctrl_o[i*XLEN +: XLEN] = ctrl_arr[i];
      assign trig_addr_o[i*XLEN +: XLEN] = cmp_arr[i];
    end
  endgenerate

  always_comb begin
    case (csr_addr)
      A_SELECT: csr_rdata = XLEN'(sel);
      A_CTRL:   csr_rdata = ctrl_arr[sel];
      A_CMP:    csr_rdata = cmp_arr[sel];
      A_CAPS:   csr_rdata = XLEN'(CAPS_MASK);
      default:  csr_rdata = '0;
    endcase
  end

  // R11
  reconf_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trig_reconf_o));

  // R10
  reconf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig_reconf_o) |-> $past(csr_we));

  // R8
  spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == A_SPARE) |-> (csr_rdata == '0));
endmodule

// File: tb/tb_dbg_trig_csr.sv
`timescale 1ns/1ps
module tb_dbg_trig_csr;
  localparam int XLEN = 32;
  localparam int NT   = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [11:0]     csr_addr = '0;
  logic            csr_we = 1'b0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic [XLEN-1:0] csr_rdata;
  logic [NT*XLEN-1:0] trig_ctrl_o, trig_addr_o;
  logic [NT-1:0]   trig_reconf_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dbg_trig_csr #(.XLEN(XLEN), .NUM_TRIG(NT)) dut (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .trig_ctrl_o(trig_ctrl_o),
    .trig_addr_o(trig_addr_o), .trig_reconf_o(trig_reconf_o)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    csr_addr = a; csr_wdata = d; csr_we = 1'b1;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    csr_addr = a; csr_we = 1'b0;
    #1 check(tag, csr_rdata, exp);
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 strobe", trig_reconf_o, 0);
    check("R1 ctrl bus", trig_ctrl_o, 64'h2000_0000_2000_0000);
    check("R1 cmp bus", trig_addr_o, 0);
    rd(12'h7A0, 0, "R1 select");
    rd(12'h7A1, 32'h2000_0000, "R1 ctrl");
    rd(12'h7A2, 0, "R1 cmp");
    rd(12'h7A3, 0, "R1 spare");
  endtask

  task automatic t_caps;
    rd(12'h7A4, 32'h44, "R9 caps");
  endtask

  task automatic t_classic;
    wr(12'h7A1, 32'h2FFF_FFFF);
    check("R11 strobe t0", trig_reconf_o, 2'b01);
    check("R11 ctrl bus", trig_ctrl_o[31:0], 32'h2003_005F);
    rd(12'h7A1, 32'h2003_005F, "R4 R5 classic all ones");
    check("R11 strobe drop", trig_reconf_o, 0);
    wr(12'h7A1, 32'h200E_0001);
    rd(12'h7A1, 32'h2002_0001, "R5 classic size kept");
  endtask

  task automatic t_ext;
    wr(12'h7A1, 32'h6FFF_FFFF);
    rd(12'h7A1, 32'h6180_005F, "R6 ext illegal size");
    wr(12'h7A1, 32'h6005_0041);
    rd(12'h7A1, 32'h6005_0041, "R6 ext size 5");
    wr(12'h7A1, 32'h6004_0001);
    rd(12'h7A1, 32'h6000_0001, "R6 ext size 4");
    wr(12'h7A1, 32'h6006_0001);
    rd(12'h7A1, 32'h6000_0001, "R6 ext size 6");
    wr(12'h7A1, 32'h6003_0009);
    rd(12'h7A1, 32'h6003_0009, "R6 ext size 3");
  endtask

  task automatic t_badkind;
    wr(12'h7A1, 32'h3000_0047);
    check("R3 no strobe", trig_reconf_o, 0);
    rd(12'h7A1, 32'h6003_0009, "R3 kind 3 dropped");
    wr(12'h7A1, 32'hF800_0047);
    rd(12'h7A1, 32'h6003_0009, "R3 kind 15 dropped");
  endtask

  task automatic t_cmp_spare;
    wr(12'h7A2, 32'hDEAD_BEEF);
    check("R11 cmp strobe", trig_reconf_o, 2'b01);
    check("R7 cmp bus", trig_addr_o[31:0], 32'hDEAD_BEEF);
    rd(12'h7A2, 32'hDEAD_BEEF, "R7 cmp read");
    wr(12'h7A3, 32'h1234_5678);
    check("R8 no strobe", trig_reconf_o, 0);
    rd(12'h7A3, 0, "R8 spare read");
    rd(12'h7A2, 32'hDEAD_BEEF, "R8 cmp untouched");
  endtask

  task automatic t_select;
    wr(12'h7A0, 32'd2);
    rd(12'h7A0, 0, "R2 select 2 refused");
    wr(12'h7A0, 32'hFFFF_FFFF);
    rd(12'h7A0, 0, "R2 select max refused");
    wr(12'h7A0, 32'd1);
    rd(12'h7A0, 1, "R2 select 1");
    rd(12'h7A1, 32'h2000_0000, "R12 trig1 ctrl");
    rd(12'h7A2, 0, "R12 trig1 cmp");
    wr(12'h7A1, 32'h2000_0044);
    check("R11 strobe t1", trig_reconf_o, 2'b10);
    check("R12 bus t1", trig_ctrl_o, {32'h2000_0044, 32'h6003_0009});
  endtask

  task automatic t_unimpl;
    wr(12'h7A5, 32'hFFFF_FFFF);
    check("R10 no strobe", trig_reconf_o, 0);
    rd(12'h7A5, 0, "R10 read 7A5");
    rd(12'h300, 0, "R10 read 300");
    rd(12'h7A0, 1, "R10 select intact");
    check("R10 buses intact", trig_addr_o, {32'h0, 32'hDEAD_BEEF});
  endtask

  task automatic t_overlap;
    wr(12'h7A0, 32'd0);
    csr_addr = 12'h7A1; csr_wdata = 32'h2001_0008; csr_we = 1'b1;
    #1 check("R11 read before edge", csr_rdata, 32'h6003_0009);
    @(negedge clk);
    csr_we = 1'b0;
    #1 check("R5 read after edge", csr_rdata, 32'h2001_0008);
    @(negedge clk);
    wr(12'h7A2, 32'h0000_1000);
    csr_addr = 12'h7A0; csr_wdata = 32'd1; csr_we = 1'b1;
    #1 check("R11 strobe during select", trig_reconf_o, 2'b01);
    @(negedge clk);
    csr_we = 1'b0;
    check("R11 strobe cleared", trig_reconf_o, 0);
    rd(12'h7A1, 32'h2000_0044, "R12 read follows select");
    check("R7 trig0 cmp bus", trig_addr_o[31:0], 32'h0000_1000);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_caps();
        t_classic();
        t_ext();
        t_badkind();
        t_cmp_spare();
        t_select();
        t_unimpl();
        t_overlap();
      end
      begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule